// File: doc/BRIEF.md
# CAN Transmit Mailbox Arbiter

This block decides which of fifteen transmit mailboxes feeds the single transmit buffer of a CAN controller. Each mailbox, numbered 1 to 15, holds an 11-bit standard identifier and a pending flag. Software writes identifiers through a simple write port and raises pending flags through a request port. Identifier storage is never reset, so its contents are undefined until written. For that reason only mailboxes whose pending flag is set take part in selection.

A mode input picks the ordering rule. In index order the lowest-numbered pending mailbox wins. In identifier order the pending mailbox with the numerically smallest identifier wins, which is the same rule the bus itself applies, and equal identifiers go to the lower mailbox number. The winner is registered as the transmit-buffer candidate, and a one-cycle load request tells the buffer to fetch it. Once the bus controller reports that a frame has started, the candidate is frozen. It stays frozen until the frame either completes, which clears that mailbox's pending flag, or loses bus arbitration, which leaves the flag set. Selection then runs again on the current pending set.

Top module: `can_tx_arbiter`

## Requirements
- R1: After reset every pending flag is 0, and `cand_valid`, `load_req` and `buf_locked` are 0.
- R2: A cycle with `req_set` high and `req_idx` in 1..15 sets the pending flag of that mailbox, shown on `pend_o` bit `req_idx-1` after that clock edge. A request with `req_idx` equal to 0 changes no flag.
- R3: With `order_by_id` = 0 the candidate is the pending mailbox with the lowest index.
- R4: With `order_by_id` = 1 the candidate is the pending mailbox with the lowest identifier value. Among equal identifiers the lower index wins.
- R5: While unlocked, the candidate (`cand_valid`, `cand_idx`, `cand_id`) reflects the pending flags and mode one clock edge after they change. `cand_valid` is 0 when nothing is pending.
- R6: `load_req` is high for exactly the one cycle after the candidate register takes on a new mailbox or identifier, or becomes valid. It is low otherwise.
- R7: While unlocked, a newly pending mailbox with higher priority replaces the current candidate.
- R8: `frame_start` with a valid candidate sets `buf_locked`. While locked the candidate holds regardless of request or mode changes, and `load_req` stays 0.
- R9: `tx_done` while locked clears the pending flag of the locked mailbox, clears `cand_valid` and `buf_locked` at the same edge, and selection resumes on the next edge. When `tx_done` and `arb_lost` are high together, `tx_done` takes precedence.
- R10: `arb_lost` while locked clears `buf_locked`, keeps the pending flag and the candidate, and re-selects on the next edge.
- R11: A request in the same cycle as `tx_done` is honoured. For a different mailbox both take effect. For the mailbox being cleared, the flag stays set.
- R12: `tx_done` and `arb_lost` while unlocked, and `frame_start` without a valid candidate, change no pending flag, lock or candidate.
- R13: A mailbox whose pending flag is clear never becomes the candidate, whatever its identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| order_by_id | input | 1 | 1: identifier order, 0: mailbox index order |
| id_we | input | 1 | Identifier write strobe |
| id_idx | input | 4 | Mailbox number to write (1..15) |
| id_data | input | 11 | Identifier value to write |
| req_set | input | 1 | Raise a pending flag |
| req_idx | input | 4 | Mailbox number of the request (1..15) |
| frame_start | input | 1 | Bus controller started sending the buffered frame |
| tx_done | input | 1 | Buffered frame sent successfully |
| arb_lost | input | 1 | Buffered frame lost bus arbitration |
| pend_o | output | 15 | Pending flags, bit n-1 for mailbox n |
| cand_valid | output | 1 | Candidate present |
| cand_idx | output | 4 | Candidate mailbox number |
| cand_id | output | 11 | Candidate identifier |
| load_req | output | 1 | One-cycle request to load the transmit buffer |
| buf_locked | output | 1 | Candidate frozen while a frame is on the bus |

## Verification
Two functions can land on the same clock edge: the clear caused by a completed frame, and a new software request. The bench raises `tx_done` together with `req_set`, first for a different mailbox and then for the very mailbox being cleared. It judges the pair by the pending vector read on the following cycle and by the candidate chosen one cycle later. The same idea is applied to `tx_done` coinciding with `arb_lost`, where the completion must win.

// File: rtl/can_txarb_pkg.sv
package can_txarb_pkg;

    localparam int unsigned STD_ID_W = 11;
    localparam int unsigned MB_COUNT = 15;
    localparam int unsigned MB_IDX_W = $clog2(MB_COUNT + 1);

    typedef enum logic {
        ORDER_BY_INDEX = 1'b0,
        ORDER_BY_ID    = 1'b1
    } order_e;

    typedef struct packed {
        logic                valid;
        logic [MB_IDX_W-1:0] idx;
        logic [STD_ID_W-1:0] id;
    } cand_t;

    // True when challenger should replace the current best entry.
    function automatic logic takes_over(
        input order_e              mode,
        input logic [STD_ID_W-1:0] challenger_id,
        input cand_t               best
    );
        if (!best.valid) begin
            return 1'b1;
        end
        return (mode == ORDER_BY_ID) && (challenger_id < best.id);
    endfunction

    function automatic logic differs(input cand_t a, input cand_t b);
        return (a.valid != b.valid) || (a.idx != b.idx) || (a.id != b.id);
    endfunction

endpackage

// File: rtl/txarb_mailbox_store.sv
module txarb_mailbox_store
    import can_txarb_pkg::*;
#(
    parameter int unsigned NUM_MB = MB_COUNT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                id_we,
    input  logic [MB_IDX_W-1:0] id_idx,
    input  logic [STD_ID_W-1:0] id_data,
    input  logic                req_set,
    input  logic [MB_IDX_W-1:0] req_idx,
    input  logic                clr_en,
    input  logic [MB_IDX_W-1:0] clr_idx,
    output logic [NUM_MB-1:0]   pend,
    output logic [STD_ID_W-1:0] ids [NUM_MB]
);

    for (genvar g = 0; g < NUM_MB; g++) begin : g_slot
        localparam logic [MB_IDX_W-1:0] SLOT_NUM = MB_IDX_W'(g + 1);

        logic [STD_ID_W-1:0] id_q;
        logic                pend_q;
        logic                hit_set;
        logic                hit_clr;

        assign hit_set = req_set && (req_idx == SLOT_NUM);
        assign hit_clr = clr_en && (clr_idx == SLOT_NUM);

        // Identifier storage is message RAM: deliberately not reset.
        always_ff @(posedge clk) begin
            if (id_we && (id_idx == SLOT_NUM)) begin
                id_q <= id_data;
            end
        end

        // A request outranks a completion clear on the same slot.
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q <= 1'b0;
            end else if (hit_set) begin
                pend_q <= 1'b1;
            end else if (hit_clr) begin
                pend_q <= 1'b0;
            end
        end

        assign pend[g] = pend_q;
        assign ids[g]  = id_q;
    end

endmodule

// File: rtl/txarb_select.sv
module txarb_select
    import can_txarb_pkg::*;
#(
    parameter int unsigned NUM_MB = MB_COUNT
) (
    input  order_e              mode,
    input  logic [NUM_MB-1:0]   pend,
    input  logic [STD_ID_W-1:0] ids [NUM_MB],
    output cand_t               win
);

    // Scan from mailbox 1 upward; a strict compare keeps ties on the
    // lower index, and index order simply keeps the first hit.
    always_comb begin
        cand_t best;
        best = '0;
        for (int i = 0; i < NUM_MB; i++) begin
            if (pend[i] && takes_over(mode, ids[i], best)) begin
                best.valid = 1'b1;
                best.idx   = MB_IDX_W'(i + 1);
                best.id    = ids[i];
            end
        end
        win = best;
    end

endmodule

// File: rtl/txarb_tx_buffer.sv
module txarb_tx_buffer
    import can_txarb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  cand_t               win,
    input  logic                frame_start,
    input  logic                tx_done,
    input  logic                arb_lost,
    output cand_t               cand,
    output logic                load_req,
    output logic                locked,
    output logic                clr_en,
    output logic [MB_IDX_W-1:0] clr_idx
);

    cand_t cand_q;
    logic  locked_q;
    logic  load_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q   <= '0;
            locked_q <= 1'b0;
            load_q   <= 1'b0;
        end else if (locked_q) begin
            load_q <= 1'b0;
            if (tx_done) begin
                locked_q     <= 1'b0;
                cand_q.valid <= 1'b0;
            end else if (arb_lost) begin
                locked_q <= 1'b0;
            end
        end else if (frame_start && cand_q.valid) begin
            locked_q <= 1'b1;
            load_q   <= 1'b0;
        end else begin
            cand_q <= win;
            load_q <= win.valid && differs(win, cand_q);
        end
    end

    assign cand     = cand_q;
    assign load_req = load_q;
    assign locked   = locked_q;
    assign clr_en   = locked_q && tx_done;
    assign clr_idx  = cand_q.idx;

endmodule

// File: rtl/can_tx_arbiter.sv
module can_tx_arbiter
    import can_txarb_pkg::*;
#(
    parameter int unsigned NUM_MB = MB_COUNT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                order_by_id,
    input  logic                id_we,
    input  logic [MB_IDX_W-1:0] id_idx,
    input  logic [STD_ID_W-1:0] id_data,
    input  logic                req_set,
    input  logic [MB_IDX_W-1:0] req_idx,
    input  logic                frame_start,
    input  logic                tx_done,
    input  logic                arb_lost,
    output logic [NUM_MB-1:0]   pend_o,
    output logic                cand_valid,
    output logic [MB_IDX_W-1:0] cand_idx,
    output logic [STD_ID_W-1:0] cand_id,
    output logic                load_req,
    output logic                buf_locked
);

    logic [STD_ID_W-1:0] ids [NUM_MB];
    logic [NUM_MB-1:0]   pend;
    logic                clr_en;
    logic [MB_IDX_W-1:0] clr_idx;
    cand_t               win;
    cand_t               cand;
    order_e              mode;

    assign mode = order_e'(order_by_id);

    txarb_mailbox_store #(.NUM_MB(NUM_MB)) u_store (
        .clk     (clk),
        .rst     (rst),
        .id_we   (id_we),
        .id_idx  (id_idx),
        .id_data (id_data),
        .req_set (req_set),
        .req_idx (req_idx),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .pend    (pend),
        .ids     (ids)
    );

    txarb_select #(.NUM_MB(NUM_MB)) u_select (
        .mode (mode),
        .pend (pend),
        .ids  (ids),
        .win  (win)
    );

    txarb_tx_buffer u_buffer (
        .clk         (clk),
        .rst         (rst),
        .win         (win),
        .frame_start (frame_start),
        .tx_done     (tx_done),
        .arb_lost    (arb_lost),
        .cand        (cand),
        .load_req    (load_req),
        .locked      (buf_locked),
        .clr_en      (clr_en),
        .clr_idx     (clr_idx)
    );

    assign pend_o     = pend;
    assign cand_valid = cand.valid;
    assign cand_idx   = cand.idx;
    assign cand_id    = cand.id;

endmodule

// File: rtl/can_tx_arbiter_chk.sv
module can_tx_arbiter_chk
    import can_txarb_pkg::*;
#(
    parameter int unsigned NUM_MB = MB_COUNT
) (
    input logic                clk,
    input logic                rst,
    input logic                order_by_id,
    input logic                id_we,
    input logic [MB_IDX_W-1:0] id_idx,
    input logic [STD_ID_W-1:0] id_data,
    input logic                req_set,
    input logic [MB_IDX_W-1:0] req_idx,
    input logic                frame_start,
    input logic                tx_done,
    input logic                arb_lost,
    input logic [NUM_MB-1:0]   pend_o,
    input logic                cand_valid,
    input logic [MB_IDX_W-1:0] cand_idx,
    input logic [STD_ID_W-1:0] cand_id,
    input logic                load_req,
    input logic                buf_locked
);

    p_set_flag_r2: assert property (@(posedge clk) disable iff (rst)
        (req_set && req_idx != 0 && req_idx <= NUM_MB)
            |=> pend_o[$past(req_idx) - 1'b1]);

    p_load_has_cand_r6: assert property (@(posedge clk) disable iff (rst)
        load_req |-> cand_valid);

    p_hold_while_locked_r8: assert property (@(posedge clk) disable iff (rst)
        (buf_locked && !tx_done && !arb_lost)
            |=> (buf_locked && cand_valid && $stable(cand_idx) && $stable(cand_id)));

    p_no_load_locked_r8: assert property (@(posedge clk) disable iff (rst)
        buf_locked |-> !load_req);

    p_done_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (buf_locked && tx_done && !(req_set && req_idx == cand_idx))
            |=> (!pend_o[$past(cand_idx) - 1'b1] && !cand_valid && !buf_locked));

    p_lost_keeps_r10: assert property (@(posedge clk) disable iff (rst)
        (buf_locked && arb_lost && !tx_done)
            |=> (pend_o[$past(cand_idx) - 1'b1] && cand_valid && !buf_locked));

    p_lock_needs_cand_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_locked) |-> ($past(frame_start) && $past(cand_valid)));

    p_cand_is_pending_r13: assert property (@(posedge clk) disable iff (rst)
        cand_valid |-> (cand_idx != 0 && pend_o[cand_idx - 1'b1]));

endmodule

bind can_tx_arbiter can_tx_arbiter_chk #(.NUM_MB(NUM_MB)) u_chk (.*);

// File: tb/can_tx_arbiter_tb.sv
`timescale 1ns/1ps
module can_tx_arbiter_tb;
    import can_txarb_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                order_by_id = 1'b0;
    logic                id_we = 1'b0;
    logic [MB_IDX_W-1:0] id_idx = '0;
    logic [STD_ID_W-1:0] id_data = '0;
    logic                req_set = 1'b0;
    logic [MB_IDX_W-1:0] req_idx = '0;
    logic                frame_start = 1'b0;
    logic                tx_done = 1'b0;
    logic                arb_lost = 1'b0;
    logic [MB_COUNT-1:0] pend_o;
    logic                cand_valid;
    logic [MB_IDX_W-1:0] cand_idx;
    logic [STD_ID_W-1:0] cand_id;
    logic                load_req;
    logic                buf_locked;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    can_tx_arbiter u_dut (
        .clk(clk), .rst(rst), .order_by_id(order_by_id),
        .id_we(id_we), .id_idx(id_idx), .id_data(id_data),
        .req_set(req_set), .req_idx(req_idx),
        .frame_start(frame_start), .tx_done(tx_done), .arb_lost(arb_lost),
        .pend_o(pend_o), .cand_valid(cand_valid), .cand_idx(cand_idx),
        .cand_id(cand_id), .load_req(load_req), .buf_locked(buf_locked)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_cand(input string req, input int v, input int idx, input int id, input int ld);
        chk(req, "cand_valid", int'(cand_valid), v);
        if (v != 0) begin
            chk(req, "cand_idx", int'(cand_idx), idx);
            chk(req, "cand_id", int'(cand_id), id);
        end
        chk(req, "load_req", int'(load_req), ld);
    endtask

    task automatic write_id(input int idx, input int id);
        id_we = 1'b1; id_idx = MB_IDX_W'(idx); id_data = STD_ID_W'(id);
        tick();
        id_we = 1'b0;
    endtask

    task automatic pulse_set(input int idx);
        req_set = 1'b1; req_idx = MB_IDX_W'(idx);
        tick();
        req_set = 1'b0;
    endtask

    task automatic pulse_start();
        frame_start = 1'b1;
        tick();
        frame_start = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        chk("R1", "pend_o", int'(pend_o), 0);
        chk_cand("R1", 0, 0, 0, 0);
        chk("R1", "buf_locked", int'(buf_locked), 0);
    endtask

    task automatic t_fill_ids();
        write_id(3, 'h100);
        write_id(7, 'h050);
        write_id(12, 'h050);
        write_id(5, 'h000);
        write_id(1, 'h001);
        write_id(2, 'h010);
    endtask

    task automatic t_index_order();
        order_by_id = 1'b0;
        pulse_set(12);
        chk("R2", "pend_o after set 12", int'(pend_o), 'h800);
        tick();
        chk_cand("R5", 1, 12, 'h050, 1);
        pulse_set(7);
        tick();
        chk_cand("R7", 1, 7, 'h050, 1);
        pulse_set(3);
        tick();
        chk_cand("R3", 1, 3, 'h100, 1);
        tick();
        chk("R6", "load_req steady", int'(load_req), 0);
        pulse_set(0);
        chk("R2", "pend_o after idx 0", int'(pend_o), 'h844);
        tick();
        chk_cand("R2", 1, 3, 'h100, 0);
    endtask

    task automatic t_id_order();
        order_by_id = 1'b1;
        tick();
        chk_cand("R4", 1, 7, 'h050, 1);
        chk("R13", "idle mailbox 5 not chosen", int'(cand_idx == 5), 0);
        tick();
        chk("R6", "load_req after id pick", int'(load_req), 0);
    endtask

    task automatic t_lock();
        pulse_start();
        chk("R8", "buf_locked", int'(buf_locked), 1);
        chk_cand("R8", 1, 7, 'h050, 0);
        pulse_set(1);
        chk("R8", "pend_o while locked", int'(pend_o), 'h845);
        tick();
        chk_cand("R8", 1, 7, 'h050, 0);
        order_by_id = 1'b0;
        tick();
        chk_cand("R8", 1, 7, 'h050, 0);
    endtask

    task automatic t_lost();
        arb_lost = 1'b1;
        tick();
        arb_lost = 1'b0;
        chk("R10", "buf_locked", int'(buf_locked), 0);
        chk("R10", "pend_o", int'(pend_o), 'h845);
        chk_cand("R10", 1, 7, 'h050, 0);
        tick();
        chk_cand("R10", 1, 1, 'h001, 1);
        order_by_id = 1'b1;
        tick();
        chk_cand("R4", 1, 1, 'h001, 0);
    endtask

    task automatic t_done();
        pulse_start();
        tx_done = 1'b1; arb_lost = 1'b1;
        tick();
        tx_done = 1'b0; arb_lost = 1'b0;
        chk("R9", "pend_o", int'(pend_o), 'h844);
        chk("R9", "buf_locked", int'(buf_locked), 0);
        chk_cand("R9", 0, 0, 0, 0);
        tick();
        chk_cand("R9", 1, 7, 'h050, 1);
    endtask

    task automatic t_same_cycle();
        pulse_start();
        tx_done = 1'b1; req_set = 1'b1; req_idx = 4'd2;
        tick();
        tx_done = 1'b0; req_set = 1'b0;
        chk("R11", "pend_o done 7 + set 2", int'(pend_o), 'h806);
        tick();
        chk_cand("R11", 1, 2, 'h010, 1);
        pulse_start();
        tx_done = 1'b1; req_set = 1'b1; req_idx = 4'd2;
        tick();
        tx_done = 1'b0; req_set = 1'b0;
        chk("R11", "pend_o done 2 + set 2", int'(pend_o), 'h806);
        chk_cand("R11", 0, 0, 0, 0);
        tick();
        chk_cand("R11", 1, 2, 'h010, 1);
    endtask

    task automatic t_ignored();
        tx_done = 1'b1;
        tick();
        tx_done = 1'b0;
        chk("R12", "pend_o after idle done", int'(pend_o), 'h806);
        chk("R12", "buf_locked after idle done", int'(buf_locked), 0);
        chk_cand("R12", 1, 2, 'h010, 0);
        arb_lost = 1'b1;
        tick();
        arb_lost = 1'b0;
        chk("R12", "pend_o after idle lost", int'(pend_o), 'h806);
        chk_cand("R12", 1, 2, 'h010, 0);
        for (int n = 0; n < 8; n++) begin
            if (!cand_valid) break;
            pulse_start();
            tx_done = 1'b1;
            tick();
            tx_done = 1'b0;
            tick();
        end
        chk("R9", "pend_o drained", int'(pend_o), 0);
        chk("R5", "cand_valid with nothing pending", int'(cand_valid), 0);
        pulse_start();
        chk("R12", "start without candidate", int'(buf_locked), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick();
        t_reset();
        t_fill_ids();
        t_index_order();
        t_id_order();
        t_lock();
        t_lost();
        t_done();
        t_same_cycle();
        t_ignored();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule